// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through SRAM Core

This block is a single-port synchronous memory with a pipelined command interface. On a rising clock edge it captures an address, a read/write select, four active-low byte-lane write enables and three chip selects. The data transfer for that command happens in the very next cycle. This holds for reads and for writes alike, so a host can alternate reads and writes on every cycle without an idle slot for bus turnaround.

Read data is flow-through. No output register sits after the array: the word selected by the captured address drives the data output combinationally during the data cycle. Write data is taken from the input port during the data cycle and stored at the closing edge of that cycle. A clock-enable input freezes the whole block. An asynchronous output enable can shut the drivers off at any moment. The bidirectional data bus is modelled as separate in, out and drive-enable ports. Burst address generation is left to a companion sequencer.

Top module: `zbt_ft_sram`

## Requirements
- R1: A read is started by an edge with `clk_en_n`=0, a valid selection (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0, `load_n`=0) and `wr_n`=1. During the following cycle, `dq_out` carries the stored word at the captured address and `dq_oe`=1 while `oe_n`=0.
- R2: A write (`wr_n`=0) takes `dq_in` during the following cycle and stores it at the end of that cycle. A read of the same address issued on that same edge returns the new word, with no idle cycle between the two.
- R3: Lane i is word bits [9i+8:9i] and is written only when `lane_we_n[i]`=0, sampled with the address. Lanes whose bit is 1 keep their old contents.
- R4: While `clk_en_n`=1, every synchronous input is ignored. The pending operation is held: a held read keeps driving the same word, and a held write is not stored until an enabled edge, which then uses `dq_in` from that edge.
- R5: If any one of the three selects is inactive, or `load_n`=1, at an enabled edge, no operation starts. No write happens, and the bus is not driven in the next cycle.
- R6: An operation already in its data phase completes even when the device is deselected on the edge that ends it.
- R7: `dq_oe` is 0 in the cycle after an edge that deselects the device or that starts a write.
- R8: `oe_n`=1 forces `dq_oe` to 0 immediately, without waiting for a clock edge.
- R9: After reset no operation is pending and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the command pipeline |
| clk_en_n | input | 1 | Active-low clock enable; 1 freezes the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Low to start a new operation on this edge |
| wr_n | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Word address |
| lane_we_n | input | LANES | Active-low write enable per 9-bit lane |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | LANES*LANE_W | Write data, sampled in the data cycle |
| dq_out | output | LANES*LANE_W | Flow-through read data |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The hardest case is a write whose data cycle is stretched by a frozen clock enable. The stored value must then come from `dq_in` at the later enabled edge, not from the values presented while the block was frozen. The stimulus issues a write and holds `clk_en_n` high for two cycles with junk on `dq_in`. One of those cycles also carries a deselect on the selects. The real data is supplied at the enabled edge, and a read issued on that same edge confirms which value was stored. A second case tests each of the four selection inputs on its own: every deselected write carries junk data, and a later read shows that the word is unchanged.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_kind_e;

    function automatic logic chip_selected(input logic a_n, input logic b,
                                           input logic c_n, input logic ld_n);
        return !a_n && b && !c_n && !ld_n;
    endfunction

endpackage

// File: rtl/zbt_issue_ctrl.sv
module zbt_issue_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              load_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we_n,
    output op_kind_e          phase_kind,
    output logic [ADDR_W-1:0] phase_addr,
    output logic [LANES-1:0]  phase_lane_en,
    output logic              commit
);

    typedef struct packed {
        op_kind_e          kind;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lane_we_n;
    } phase_t;

    phase_t ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (!clk_en_n) begin
            if (chip_selected(sel_a_n, sel_b, sel_c_n, load_n)) begin
                ph_d.kind      = wr_n ? OP_READ : OP_WRITE;
                ph_d.addr      = addr;
                ph_d.lane_we_n = lane_we_n;
            end else begin
                ph_d.kind = OP_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '{kind: OP_IDLE, addr: '0, lane_we_n: '1};
        end else begin
            ph_q <= ph_d;
        end
    end

    assign phase_kind    = ph_q.kind;
    assign phase_addr    = ph_q.addr;
    assign phase_lane_en = ~ph_q.lane_we_n;
    assign commit        = (ph_q.kind == OP_WRITE) && !clk_en_n;

endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    commit,
    input  logic [ADDR_W-1:0]       word_addr,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (commit && lane_en[l]) begin
                cells[word_addr] <= wr_data[l*LANE_W +: LANE_W];
            end
        end

        assign rd_data[l*LANE_W +: LANE_W] = cells[word_addr];
    end

endmodule

// File: rtl/zbt_out_drive.sv
module zbt_out_drive
    import zbt_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  op_kind_e          phase_kind,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    logic rd_phase;

    always_comb begin
        rd_phase = (phase_kind == OP_READ);
        dq_out   = rd_phase ? rd_data : '0;
        dq_oe    = rd_phase && !oe_n;
    end

endmodule

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    load_n,
    input  logic                    wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);

    localparam int DATA_W = LANES * LANE_W;

    op_kind_e          phase_kind;
    logic [ADDR_W-1:0] phase_addr;
    logic [LANES-1:0]  phase_lane_en;
    logic              commit;
    logic [DATA_W-1:0] rd_data;

    zbt_issue_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .clk_en_n      (clk_en_n),
        .sel_a_n       (sel_a_n),
        .sel_b         (sel_b),
        .sel_c_n       (sel_c_n),
        .load_n        (load_n),
        .wr_n          (wr_n),
        .addr          (addr),
        .lane_we_n     (lane_we_n),
        .phase_kind    (phase_kind),
        .phase_addr    (phase_addr),
        .phase_lane_en (phase_lane_en),
        .commit        (commit)
    );

    zbt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk       (clk),
        .commit    (commit),
        .word_addr (phase_addr),
        .lane_en   (phase_lane_en),
        .wr_data   (dq_in),
        .rd_data   (rd_data)
    );

    zbt_out_drive #(.DATA_W(DATA_W)) u_drive (
        .phase_kind (phase_kind),
        .oe_n       (oe_n),
        .rd_data    (rd_data),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );

endmodule

// File: rtl/zbt_ft_sram_chk.sv
module zbt_ft_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              sel_a_n,
    input logic              sel_b,
    input logic              sel_c_n,
    input logic              load_n,
    input logic              wr_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe
);

    logic start;
    assign start = !sel_a_n && sel_b && !sel_c_n && !load_n;

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && start && wr_n) |=> (oe_n || dq_oe));                 // R1

    AST_HOLD_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(dq_out));                                       // R4

    AST_HOLD_KEEPS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_n && !oe_n) |=> (oe_n || $stable(dq_oe)));                   // R4

    AST_DESELECT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !start) |=> !dq_oe);                                   // R5

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && start && !wr_n) |=> !dq_oe);                           // R7

    AST_OE_GATES_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);                                                    // R8

endmodule

bind zbt_ft_sram zbt_ft_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .sel_a_n  (sel_a_n),
    .sel_b    (sel_b),
    .sel_c_n  (sel_c_n),
    .load_n   (load_n),
    .wr_n     (wr_n),
    .oe_n     (oe_n),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
);

// File: tb/zbt_ft_sram_tb.sv
module zbt_ft_sram_tb;

    localparam int AW = 10;
    localparam int LANES = 4;
    localparam int LW = 9;
    localparam int DW = LANES * LW;
    // ce = {load_n, sel_c_n, sel_b, sel_a_n}
    localparam logic [3:0] SEL   = 4'b0010;
    localparam logic [3:0] DESEL = 4'b0011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en_n = 1'b0;
    logic sel_a_n = 1'b1, sel_b = 1'b1, sel_c_n = 1'b0, load_n = 1'b0;
    logic wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [LANES-1:0] lane_we_n = '1;
    logic oe_n = 1'b0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic dq_oe;

    always #5 clk = ~clk;

    zbt_ft_sram #(.ADDR_W(AW), .LANES(LANES), .LANE_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .load_n(load_n),
        .wr_n(wr_n), .addr(addr), .lane_we_n(lane_we_n), .oe_n(oe_n),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    typedef struct {
        int            due;
        bit            drv;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    exp_t          sbq[$];
    logic [DW-1:0] model [int];
    int            cyc = 0;
    int            n_cmp = 0;
    int            n_bad = 0;
    int            pk = 0;      // 0 idle, 1 read, 2 write (bench view of data phase)
    int            pa = 0;
    logic [3:0]    pm = '1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return {4'h0, 32'h9E37_79B9 * (i + 1)} ^ {i[8:0], 27'h0};
    endfunction

    // Driver: one cycle of stimulus; din serves the op whose data phase is this cycle.
    task automatic step(input bit en, input logic [3:0] ce, input bit wr, input int a,
                        input logic [3:0] wen_n, input logic [DW-1:0] din, input string tag);
        exp_t e;
        logic [DW-1:0] w;
        @(posedge clk);
        #1;
        clk_en_n = !en;
        {load_n, sel_c_n, sel_b, sel_a_n} = ce;
        wr_n = !wr;
        addr = a[AW-1:0];
        lane_we_n = wen_n;
        dq_in = din;
        if (en) begin
            if (pk == 2) begin
                w = model.exists(pa) ? model[pa] : '0;
                for (int l = 0; l < LANES; l++)
                    if (!pm[l]) w[l*LW +: LW] = din[l*LW +: LW];
                model[pa] = w;
            end
            if (ce == SEL) begin
                pk = wr ? 2 : 1;
                pa = a;
                pm = wen_n;
            end else begin
                pk = 0;
            end
        end
        e.due  = cyc + 1;
        e.drv  = (pk == 1);
        e.data = (pk == 1 && model.exists(pa)) ? model[pa] : '0;
        e.tag  = tag;
        sbq.push_back(e);
    endtask

    // Monitor: compares each data-phase cycle against the queued expectation.
    always @(negedge clk) begin
        exp_t e;
        if (sbq.size() > 0 && sbq[0].due == cyc) begin
            e = sbq.pop_front();
            check(dq_oe == (e.drv && !oe_n), e.tag, "dq_oe", DW'(dq_oe), DW'(e.drv && !oe_n));
            if (e.drv && !oe_n)
                check(dq_out == e.data, e.tag, "dq_out", dq_out, e.data);
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check(dq_oe == 1'b0, "R9", "dq_oe in reset", DW'(dq_oe), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dq_oe == 1'b0, "R9", "dq_oe after reset", DW'(dq_oe), '0);

        // R1/R2: alternating write then read of the same word, no idle cycle
        for (int i = 0; i < 8; i++) begin
            step(1, SEL, 1, i * 37, 4'h0, '0, "R2");
            step(1, SEL, 0, i * 37, 4'hF, pat(i), "R2");
        end
        // R1: back-to-back writes then back-to-back reads
        step(1, SEL, 1, 400, 4'h0, '0, "R1");
        step(1, SEL, 1, 401, 4'h0, pat(20), "R1");
        step(1, SEL, 0, 400, 4'hF, pat(21), "R1");
        step(1, SEL, 0, 401, 4'hF, '0, "R1");

        // R3: partial lane writes (lanes 0 and 2, then lane 3 only)
        step(1, SEL, 1, 5, 4'b1010, '0, "R3");
        step(1, SEL, 0, 5, 4'hF, {DW{1'b1}}, "R3");
        step(1, SEL, 1, 74, 4'b0111, '0, "R3");
        step(1, SEL, 0, 74, 4'hF, 36'h0_5A5A_5A5A, "R3");

        // R4: held write takes data at the enabled edge, not while frozen
        step(1, SEL, 1, 9, 4'h0, '0, "R4");
        step(0, SEL, 0, 12, 4'h0, 36'hF_FFFF_0000, "R4");
        step(0, DESEL, 0, 13, 4'h0, 36'hE_EEEE_EEEE, "R4");
        step(1, SEL, 0, 9, 4'hF, 36'h1_2345_6789, "R4");
        // R4: held read keeps driving the same word
        step(1, SEL, 0, 37, 4'hF, '0, "R4");
        step(0, SEL, 1, 74, 4'h0, '0, "R4");
        step(0, DESEL, 0, 5, 4'hF, '0, "R4");
        step(1, DESEL, 0, 0, 4'hF, '0, "R4");

        // R5: each selection input alone blocks a write
        step(1, SEL, 1, 20, 4'h0, '0, "R5");
        step(1, DESEL, 0, 0, 4'hF, 36'h0_0000_0C0D, "R5");
        step(1, 4'b0011, 1, 20, 4'h0, '0, "R5");
        step(1, DESEL, 0, 0, 4'hF, {DW{1'b1}}, "R5");
        step(1, 4'b0000, 1, 20, 4'h0, '0, "R5");
        step(1, DESEL, 0, 0, 4'hF, {DW{1'b1}}, "R5");
        step(1, 4'b0110, 1, 20, 4'h0, '0, "R5");
        step(1, DESEL, 0, 0, 4'hF, {DW{1'b1}}, "R5");
        step(1, 4'b1010, 1, 20, 4'h0, '0, "R5");
        step(1, DESEL, 0, 0, 4'hF, {DW{1'b1}}, "R5");
        step(1, SEL, 0, 20, 4'hF, '0, "R5");
        step(1, DESEL, 0, 0, 4'hF, '0, "R7");

        // R6: pending write and read complete across a deselect
        step(1, SEL, 1, 30, 4'h0, '0, "R6");
        step(1, DESEL, 0, 0, 4'hF, 36'hA_BCDE_F012, "R6");
        step(1, SEL, 0, 30, 4'hF, '0, "R6");
        step(1, DESEL, 0, 0, 4'hF, '0, "R6");

        // R8: output enable acts without a clock edge
        step(1, SEL, 0, 401, 4'hF, '0, "R8");
        step(1, DESEL, 0, 0, 4'hF, '0, "R8");
        @(negedge clk);
        #1;
        oe_n = 1'b1;
        #1;
        check(dq_oe == 1'b0, "R8", "dq_oe with oe_n high", DW'(dq_oe), '0);
        oe_n = 1'b0;
        #1;
        check(dq_oe == 1'b1, "R8", "dq_oe with oe_n low again", DW'(dq_oe), DW'(1));

        repeat (3) step(1, DESEL, 0, 0, 4'hF, '0, "R7");
        repeat (2) @(posedge clk);
        summary();
        $finish;
    end

endmodule